// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block is a direct-mapped data cache placed between a processor that issues single-word loads and stores and a lower-level memory that moves whole lines. It stores 256 lines, each four 32-bit words wide. Every incoming byte address is divided into a line tag, a line index, a word-within-line offset and a byte offset. A lookup hits when the indexed line is valid and its stored tag equals the tag of the request.

Stores use write-back with allocation on a miss, and each line has a dirty flag. On any miss the requester is held off. If the victim line is dirty it is first written to the lower level. The whole new line is then fetched and installed, and after one settle cycle the held request is served from the freshly filled line. Because a store that misses always waits for the complete refill before its word is merged, a line never combines a new tag with stale words from the previous occupant.

Both ports use valid/ready. On the processor side the requester raises `cpu_valid` and must hold the address, write flag, data and byte enables steady until it sees `cpu_ready` high at a clock edge. That edge is the acceptance. Read data comes back one cycle later with `cpu_rvalid`. On the memory side the cache raises `mem_valid` and keeps address, direction and write data steady until `mem_ready` is sampled high. `mem_ready` may be delayed any number of cycles. For a line read, `mem_rdata` must be valid in the same cycle as `mem_ready`.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address is decoded as tag = bits [31:12], index = bits [11:4], word offset = bits [3:2], byte offset = bits [1:0]. Addresses that differ only in bits [3:0] share a line. Addresses that differ only in the tag map to the same line and displace each other.
- R2: A request is accepted with no stall cycle only when the indexed line is valid and its tag matches. An accepted read returns the addressed word on `cpu_rdata` with `cpu_rvalid` high exactly one cycle after acceptance.
- R3: After reset every line is invalid, `stall`, `mem_valid` and `cpu_rvalid` are low, and the first access to any line misses.
- R4: On a read miss the request stalls, one line read is issued to the block-aligned address {tag, index, 4'b0}, the line is installed, and the requested word is then delivered.
- R5: A store hit updates the cached word, marks the line dirty and issues no lower-level transfer.
- R6: When a miss replaces a valid dirty line, that line is written back (address {old tag, index, 4'b0}, with its current contents) before the refill read starts. A clean or invalid victim produces no write-back.
- R7: A store miss first refills the whole line and only then merges the store word. The other three words keep their lower-level values, and the line becomes dirty.
- R8: On a store, byte lane k (cpu_wdata bits [8k+7:8k]) is written only when cpu_be[k] is 1. The other bytes of the word are kept.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we` and `mem_addr` stay unchanged. Any acknowledge latency is tolerated.
- R10: `stall` is high in every cycle in which a valid request is not accepted, from the cycle the miss is detected until the request is served. `cpu_ready` and `stall` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request accepted at this edge |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 32 | Load data |
| stall | output | 1 | Request held off by a miss |
| mem_valid | output | 1 | Lower-level transfer request |
| mem_ready | input | 1 | Lower-level acknowledge |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wdata | output | 128 | Line data for write-back |
| mem_rdata | input | 128 | Line data for refill |

## Verification
A wrong valid flag or tag shows up immediately as a hit/miss mismatch: a stall on an access the reference model calls a hit, or a missing stall on a predicted miss, in the cycle the request is presented. A wrong dirty flag shows up only at the next eviction of that line, as a missing or extra write-back. Corrupted line contents show up either at the next load of the affected word or in the write-back data compared against the bench's view of memory. The bench drives accesses into a small set of indices and tags so that evictions, and therefore these later symptoms, occur within a few dozen accesses.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WBACK   = 2'd1,
    ST_REFILL  = 2'd2,
    ST_RESPOND = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W    = 32,
  parameter int BYTE_BITS = 2,
  parameter int OFF_BITS  = 2,
  parameter int IDX_BITS  = 8,
  parameter int TAG_BITS  = 20
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [TAG_BITS-1:0] tag_o,
  output logic [IDX_BITS-1:0] idx_o,
  output logic [OFF_BITS-1:0] off_o
);
  localparam int IDX_LO = BYTE_BITS + OFF_BITS;
  localparam int TAG_LO = IDX_LO + IDX_BITS;

  logic unused_byte_bits;

  assign off_o = addr_i[BYTE_BITS +: OFF_BITS];
  assign idx_o = addr_i[IDX_LO +: IDX_BITS];
  assign tag_o = addr_i[TAG_LO +: TAG_BITS];
  assign unused_byte_bits = ^addr_i[BYTE_BITS-1:0];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES    = 256,
  parameter int IDX_BITS = 8,
  parameter int TAG_BITS = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_BITS-1:0] idx_i,
  input  logic [TAG_BITS-1:0] tag_i,
  input  logic                install_i,
  input  logic                set_dirty_i,
  output logic                hit_o,
  output logic                vic_valid_o,
  output logic                vic_dirty_o,
  output logic [TAG_BITS-1:0] vic_tag_o
);
  logic [LINES-1:0]    valid_q;
  logic [LINES-1:0]    dirty_q;
  logic [TAG_BITS-1:0] tag_q [LINES];

  // State flags are reset; the tag array is not, since valid guards it.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (install_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (set_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install_i) tag_q[idx_i] <= tag_i;
  end

  assign vic_valid_o = valid_q[idx_i];
  assign vic_dirty_o = dirty_q[idx_i];
  assign vic_tag_o   = tag_q[idx_i];
  assign hit_o       = valid_q[idx_i] && (tag_q[idx_i] == tag_i);

  AST_DIRTY_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    (set_dirty_i && !install_i) |=> dirty_q[$past(idx_i)]); // R5

  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    install_i |=> (valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)])); // R7
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES    = 256,
  parameter int IDX_BITS = 8,
  parameter int WORDS    = 4,
  parameter int WORD_W   = 32,
  parameter int OFF_BITS = 2,
  localparam int LINE_W  = WORDS * WORD_W,
  localparam int BE_W    = WORD_W / 8
) (
  input  logic                clk,
  input  logic [IDX_BITS-1:0] idx_i,
  input  logic [OFF_BITS-1:0] off_i,
  input  logic                fill_i,
  input  logic [LINE_W-1:0]   fill_data_i,
  input  logic                wr_i,
  input  logic [BE_W-1:0]     be_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [LINE_W-1:0]   line_o,
  output logic [WORD_W-1:0]   word_o
);
  logic [LINE_W-1:0] mem_q [LINES];
  logic [LINE_W-1:0] cur_line;
  logic [LINE_W-1:0] merged;
  logic [WORD_W-1:0] words [WORDS];

  assign cur_line = mem_q[idx_i];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] upd;
    logic              sel;
    assign sel = wr_i && (off_i == OFF_BITS'(w));
    always_comb begin
      for (int b = 0; b < BE_W; b++) begin
        upd[b*8 +: 8] = (sel && be_i[b]) ? wdata_i[b*8 +: 8]
                                         : cur_line[w*WORD_W + b*8 +: 8];
      end
    end
    assign merged[w*WORD_W +: WORD_W] = upd;
    assign words[w] = cur_line[w*WORD_W +: WORD_W];
  end

  // A refill replaces the whole line; a store rewrites one merged word.
  always_ff @(posedge clk) begin
    if (fill_i)    mem_q[idx_i] <= fill_data_i;
    else if (wr_i) mem_q[idx_i] <= merged;
  end

  assign line_o = cur_line;
  assign word_o = words[off_i];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TAG_BITS = 20,
  parameter int IDX_BITS = 8,
  parameter int BLK_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_valid_i,
  input  logic                cpu_write_i,
  input  logic                hit_i,
  input  logic                vic_valid_i,
  input  logic                vic_dirty_i,
  input  logic [TAG_BITS-1:0] vic_tag_i,
  input  logic [TAG_BITS-1:0] req_tag_i,
  input  logic [IDX_BITS-1:0] idx_i,
  input  logic                mem_ready_i,
  output logic                cpu_ready_o,
  output logic                stall_o,
  output logic                mem_valid_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                install_o,
  output logic                accept_o,
  output logic                store_o
);
  ctl_state_t state_q, state_d;
  logic       miss;

  assign miss = cpu_valid_i && !hit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (miss) state_d = (vic_valid_i && vic_dirty_i) ? ST_WBACK : ST_REFILL;
      ST_WBACK:   if (mem_ready_i) state_d = ST_REFILL;
      ST_REFILL:  if (mem_ready_i) state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign cpu_ready_o = (state_q == ST_IDLE) && cpu_valid_i && hit_i;
  assign stall_o     = (state_q != ST_IDLE) || miss;
  assign accept_o    = cpu_ready_o;
  assign store_o     = cpu_ready_o && cpu_write_i;
  assign mem_valid_o = (state_q == ST_WBACK) || (state_q == ST_REFILL);
  assign mem_we_o    = (state_q == ST_WBACK);
  assign install_o   = (state_q == ST_REFILL) && mem_ready_i;
  assign mem_addr_o  = (state_q == ST_WBACK) ? {vic_tag_i, idx_i, {BLK_BITS{1'b0}}}
                                             : {req_tag_i, idx_i, {BLK_BITS{1'b0}}};

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_we_o) && $stable(mem_addr_o))); // R9

  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && mem_we_o && mem_ready_i) |=> (mem_valid_o && !mem_we_o)); // R6

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (vic_valid_i && vic_dirty_i)); // R6

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REFILL && mem_ready_i) |=> hit_i); // R4
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 256,
  localparam int BE_W      = WORD_W / 8,
  localparam int LINE_W    = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              stall,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata
);
  localparam int BYTE_BITS = $clog2(BE_W);
  localparam int OFF_BITS  = $clog2(WORDS);
  localparam int IDX_BITS  = $clog2(LINES);
  localparam int BLK_BITS  = BYTE_BITS + OFF_BITS;
  localparam int TAG_BITS  = ADDR_W - IDX_BITS - BLK_BITS;

  logic [TAG_BITS-1:0] req_tag, vic_tag;
  logic [IDX_BITS-1:0] req_idx;
  logic [OFF_BITS-1:0] req_off;
  logic                hit, vic_valid, vic_dirty;
  logic                install, accept, store;
  logic [WORD_W-1:0]   hit_word;

  dmc_addr_split #(
    .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .OFF_BITS(OFF_BITS),
    .IDX_BITS(IDX_BITS), .TAG_BITS(TAG_BITS)
  ) u_split (
    .addr_i(cpu_addr), .tag_o(req_tag), .idx_o(req_idx), .off_o(req_off)
  );

  dmc_tag_store #(
    .LINES(LINES), .IDX_BITS(IDX_BITS), .TAG_BITS(TAG_BITS)
  ) u_tags (
    .clk(clk), .rst(rst), .idx_i(req_idx), .tag_i(req_tag),
    .install_i(install), .set_dirty_i(store), .hit_o(hit),
    .vic_valid_o(vic_valid), .vic_dirty_o(vic_dirty), .vic_tag_o(vic_tag)
  );

  dmc_data_store #(
    .LINES(LINES), .IDX_BITS(IDX_BITS), .WORDS(WORDS),
    .WORD_W(WORD_W), .OFF_BITS(OFF_BITS)
  ) u_data (
    .clk(clk), .idx_i(req_idx), .off_i(req_off), .fill_i(install),
    .fill_data_i(mem_rdata), .wr_i(store), .be_i(cpu_be),
    .wdata_i(cpu_wdata), .line_o(mem_wdata), .word_o(hit_word)
  );

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .TAG_BITS(TAG_BITS), .IDX_BITS(IDX_BITS), .BLK_BITS(BLK_BITS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write),
    .hit_i(hit), .vic_valid_i(vic_valid), .vic_dirty_i(vic_dirty),
    .vic_tag_i(vic_tag), .req_tag_i(req_tag), .idx_i(req_idx),
    .mem_ready_i(mem_ready), .cpu_ready_o(cpu_ready), .stall_o(stall),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .install_o(install), .accept_o(accept), .store_o(store)
  );

  // Load data is registered: one cycle from acceptance to cpu_rvalid.
  always_ff @(posedge clk) begin
    if (rst) cpu_rvalid <= 1'b0;
    else     cpu_rvalid <= accept && !cpu_write;
  end

  always_ff @(posedge clk) begin
    if (accept && !cpu_write) cpu_rdata <= hit_word;
  end
endmodule

// File: tb/sim_dm_wb_cache.sv
module sim_dm_wb_cache;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]   cpu_be = '0;
  logic         cpu_ready, cpu_rvalid, stall, mem_valid, mem_we;
  logic [31:0]  cpu_rdata, mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ready = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #4 clk = ~clk;

  dm_wb_cache u0 (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .stall(stall), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0;
  int misses = 0, wb_count = 0, txn = 0, lat = 1, wcnt = 0;
  logic [127:0] back [int unsigned];
  logic [31:0]  gold [int unsigned];
  logic [19:0]  m_tag [256];
  bit           m_val [256];
  bit           m_dirty [256];
  bit           wb_pend = 0;
  logic [31:0]  wb_addr = '0, fill_addr = '0, prev_addr = '0;
  bit           prev_wait = 0, prev_we = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input int unsigned w);
    return (w * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] gold_word(input int unsigned w);
    return gold.exists(w) ? gold[w] : init_word(w);
  endfunction

  function automatic logic [127:0] back_line(input int unsigned b);
    if (back.exists(b)) return back[b];
    return {init_word(b*4+3), init_word(b*4+2), init_word(b*4+1), init_word(b*4)};
  endfunction

  function automatic logic [127:0] gold_line(input int unsigned b);
    return {gold_word(b*4+3), gold_word(b*4+2), gold_word(b*4+1), gold_word(b*4)};
  endfunction

  // Lower-level memory with variable acknowledge latency, checked every clock.
  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0; wcnt = 0; prev_wait = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0; wcnt = 0; prev_wait = 0;
    end else if (mem_valid) begin
      if (prev_wait)
        chk(mem_addr === prev_addr && mem_we === prev_we, "R9", "request changed while waiting",
            {96'd0, mem_addr}, {96'd0, prev_addr});
      if (wcnt >= lat) begin
        if (mem_we) begin
          chk(wb_pend, "R6", "unexpected write-back", {96'd0, mem_addr}, 128'd0);
          chk(mem_addr === wb_addr, "R6", "write-back address", {96'd0, mem_addr}, {96'd0, wb_addr});
          chk(mem_wdata === gold_line(mem_addr >> 4), "R6", "write-back data",
              mem_wdata, gold_line(mem_addr >> 4));
          back[mem_addr >> 4] = mem_wdata;
          wb_pend = 0;
          wb_count++;
        end else begin
          chk(!wb_pend, "R6", "refill before write-back", {96'd0, mem_addr}, {96'd0, wb_addr});
          chk(mem_addr === fill_addr, "R4", "refill address", {96'd0, mem_addr}, {96'd0, fill_addr});
          mem_rdata = back_line(mem_addr >> 4);
        end
        mem_ready = 1'b1;
        txn++;
        lat = (txn * 3) % 5;
        prev_wait = 0;
      end else begin
        wcnt++;
        prev_wait = 1; prev_addr = mem_addr; prev_we = mem_we;
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [3:0] be, input string req);
    int unsigned idx = addr[11:4];
    logic [19:0] tag = addr[31:12];
    bit          exp_hit = m_val[idx] && (m_tag[idx] == tag);
    logic [31:0] exp_word = gold_word(addr >> 2);
    logic [31:0] nw;
    int          stalls = 0;
    if (!exp_hit) begin
      if (m_val[idx] && m_dirty[idx]) begin
        wb_pend = 1;
        wb_addr = {m_tag[idx], addr[11:4], 4'b0};
      end
      fill_addr = {tag, addr[11:4], 4'b0};
      m_val[idx] = 1; m_tag[idx] = tag; m_dirty[idx] = 0;
    end
    if (wr) begin
      nw = exp_word;
      for (int b = 0; b < 4; b++) if (be[b]) nw[b*8 +: 8] = wd[b*8 +: 8];
      gold[addr >> 2] = nw;
      m_dirty[idx] = 1;
    end
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
    forever begin
      #1;
      if (cpu_ready) break;
      chk(stall === 1'b1, "R10", "stall while waiting", {127'd0, stall}, 128'd1);
      stalls++;
      if (stalls > 300) break;
      @(negedge clk);
    end
    chk(stall === 1'b0, "R10", "stall with ready", {127'd0, stall}, 128'd0);
    @(negedge clk);
    cpu_valid = 0;
    if (stalls > 0) misses++;
    chk((stalls == 0) == exp_hit, req, "hit/miss outcome", {96'd0, stalls}, {127'd0, !exp_hit});
    if (!exp_hit)
      chk(stalls >= 2, "R4", "miss stall length", {96'd0, stalls}, 128'd2);
    chk(!wb_pend, "R6", "write-back not performed", {127'd0, wb_pend}, 128'd0);
    #1;
    if (wr) begin
      chk(cpu_rvalid === 1'b0, req, "rvalid after store", {127'd0, cpu_rvalid}, 128'd0);
    end else begin
      chk(cpu_rvalid === 1'b1, "R2", "rvalid after load", {127'd0, cpu_rvalid}, 128'd1);
      chk(cpu_rdata === exp_word, req, "load data", {96'd0, cpu_rdata}, {96'd0, exp_word});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base_wb;
    logic [19:0] tags [4] = '{20'h00000, 20'h00001, 20'h00002, 20'hFFFFF};
    for (int i = 0; i < 256; i++) begin m_val[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R3: idle outputs after reset
    chk(stall === 0 && mem_valid === 0 && cpu_rvalid === 0, "R3", "reset outputs",
        {125'd0, stall, mem_valid, cpu_rvalid}, 128'd0);

    // R1/R4: word string 0 1 2 3 4 3 4 15 -> three line misses
    misses = 0;
    access(0, 32'h00, '0, 4'h0, "R3");
    access(0, 32'h04, '0, 4'h0, "R1");
    access(0, 32'h08, '0, 4'h0, "R1");
    access(0, 32'h0C, '0, 4'h0, "R1");
    access(0, 32'h10, '0, 4'h0, "R4");
    access(0, 32'h0C, '0, 4'h0, "R2");
    access(0, 32'h10, '0, 4'h0, "R2");
    access(0, 32'h3C, '0, 4'h0, "R4");
    chk(misses == 3, "R1", "misses in word string", {96'd0, misses}, 128'd3);

    // R5: store hit, no lower traffic
    base_wb = wb_count;
    access(1, 32'h04, 32'hDEADBEEF, 4'hF, "R5");
    access(0, 32'h04, '0, 4'h0, "R5");
    chk(wb_count == base_wb, "R5", "store hit lower writes", {96'd0, wb_count}, {96'd0, base_wb});

    // R8: partial byte enables
    access(1, 32'h08, 32'h11223344, 4'b0101, "R8");
    access(0, 32'h08, '0, 4'h0, "R8");
    access(1, 32'h08, 32'hAABBCCDD, 4'b1000, "R8");
    access(0, 32'h08, '0, 4'h0, "R8");

    // R6: dirty conflict at tag 1 same index
    base_wb = wb_count;
    access(0, 32'h1000, '0, 4'h0, "R6");
    chk(wb_count == base_wb + 1, "R6", "dirty eviction", {96'd0, wb_count}, {96'd0, base_wb + 1});
    // R6: clean ping-pong, no write-back, every access misses
    misses = 0; base_wb = wb_count;
    access(0, 32'h0000, '0, 4'h0, "R1");
    access(0, 32'h1004, '0, 4'h0, "R1");
    access(0, 32'h0008, '0, 4'h0, "R1");
    access(0, 32'h100C, '0, 4'h0, "R1");
    chk(misses == 4, "R1", "conflict misses", {96'd0, misses}, 128'd4);
    chk(wb_count == base_wb, "R6", "clean eviction", {96'd0, wb_count}, {96'd0, base_wb});

    // R7: store miss refills then merges
    access(1, 32'h2008, 32'hCAFEF00D, 4'b1100, "R7");
    access(0, 32'h2000, '0, 4'h0, "R7");
    access(0, 32'h2004, '0, 4'h0, "R7");
    access(0, 32'h2008, '0, 4'h0, "R7");
    access(0, 32'h200C, '0, 4'h0, "R7");
    base_wb = wb_count;
    access(0, 32'h0000, '0, 4'h0, "R6");
    chk(wb_count == base_wb + 1, "R7", "stored line dirty", {96'd0, wb_count}, {96'd0, base_wb + 1});

    // R1: highest tag value
    access(1, 32'hFFFFF0F4, 32'h0BADC0DE, 4'hF, "R1");
    access(0, 32'hFFFFF0F4, '0, 4'h0, "R1");

    // Mixed traffic over few indices and tags
    for (int n = 0; n < 500; n++) begin
      logic [31:0] a;
      a = {tags[$urandom_range(0, 3)], 4'h0, 4'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), 2'b00};
      if ($urandom_range(0, 2) == 0)
        access(1, a, $urandom, 4'($urandom_range(1, 15)), "R8");
      else
        access(0, a, '0, 4'h0, "R2");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule